// File: doc/BRIEF.md
# Block-Instruction Repeat Controller

This block takes the loop decision for the repeating block instructions of an 8-bit processor: memory-to-memory transfer, compare/search, and port input or output. The datapath performs one iteration, decrements its counters and computes its flags. It then strobes this controller with the instruction class, the 16-bit pair counter after the decrement, the 8-bit byte counter after the decrement, the zero flag from the compare, and the address of the instruction.

One cycle later the controller reports its decision with a single-cycle valid pulse. The report holds the repeat flag, the program counter to resume from, the extra clock states to charge, and an optional write of the hidden address-tracking register. When the loop continues, the program counter steps back over the two-byte instruction so that the instruction is fetched again. When the loop ends, the address passes through unchanged.

Top module: `brep_ctrl`

## Requirements
- R1: Class encoding `cls` = 0 (transfer): the loop repeats exactly when `pair_cnt` is nonzero.
- R2: Class `cls` = 1 (search): the loop repeats only when `pair_cnt` is nonzero and `zf` is 0, so a match (`zf` = 1) ends it.
- R3: Class `cls` = 2 (port input/output): the loop repeats exactly when `byte_cnt` is nonzero. `pair_cnt` and `zf` have no influence.
- R4: On a repeat, `pc_next` equals `pc_in` minus 2, modulo 2^16, and `extra_t` equals 5.
- R5: On a repeat of class 0 or 1, `mp_we` is 1 and `mp_val` equals `pc_next` + 1. On a repeat of class 2, `mp_we` stays 0.
- R6: When the loop does not repeat, `pc_next` equals `pc_in`, `extra_t` is 0 and `mp_we` is 0.
- R7: `rsp_valid` is high for exactly the one cycle after each cycle in which `iter_done` is high. Back-to-back strobes give back-to-back reports, and there is no report without a strobe.
- R8: A pair count that has just reached 0x0000 ends the loop. A count of 0xFFFF, which is what a loop started at zero shows after its first iteration, keeps it running, which gives 65536 iterations.
- R9: Class `cls` = 3 is reserved and never repeats.
- R10: While `rst_n` is low and after its release, `rsp_valid`, `rpt` and `mp_we` are 0 until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iter_done | input | 1 | One iteration finished; inputs valid this cycle |
| cls | input | 2 | Instruction class: 0 transfer, 1 search, 2 port I/O, 3 reserved |
| pair_cnt | input | 16 | Pair counter after this iteration's decrement |
| byte_cnt | input | 8 | Byte counter after this iteration's decrement |
| zf | input | 1 | Zero flag of the compare |
| pc_in | input | 16 | Program counter after the instruction's two bytes were fetched |
| rsp_valid | output | 1 | Decision valid, one-cycle pulse |
| rpt | output | 1 | Loop continues |
| pc_next | output | 16 | Program counter to resume from |
| extra_t | output | 4 | Extra clock states to charge |
| mp_we | output | 1 | Write the hidden address register |
| mp_val | output | 16 | Value for the hidden address register |

## Verification
Every result of a strobe, whether decision, address, charge or register write, is due in the single cycle that directly follows the strobe edge. Nothing is due earlier or later. The driver applies inputs on the falling edge and queues the expected report. The monitor samples on each falling edge, so it sees the register state one half period after the edge that produced it. When `rsp_valid` is high, the monitor pops exactly one entry and compares all fields. A pulse with an empty queue is reported as a failure, and so is an entry left over at the end.

// File: rtl/brep_ctrl.sv
module brep_ctrl #(
  parameter int AW       = 16,
  parameter int CW       = 8,
  parameter int TW       = 4,
  parameter int PC_BACK  = 2,
  parameter int EXTRA_T  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iter_done,
  input  logic [1:0]    cls,
  input  logic [AW-1:0] pair_cnt,
  input  logic [CW-1:0] byte_cnt,
  input  logic          zf,
  input  logic [AW-1:0] pc_in,
  output logic          rsp_valid,
  output logic          rpt,
  output logic [AW-1:0] pc_next,
  output logic [TW-1:0] extra_t,
  output logic          mp_we,
  output logic [AW-1:0] mp_val
);
  localparam logic [1:0] CL_XFER = 2'd0;
  localparam logic [1:0] CL_SRCH = 2'd1;
  localparam logic [1:0] CL_PORT = 2'd2;
  localparam logic [AW-1:0] BACK = AW'(PC_BACK);
  localparam logic [TW-1:0] XT   = TW'(EXTRA_T);

  typedef enum logic {ST_IDLE, ST_REPORT} st_t;
  st_t st_q;

  logic go;
  logic [AW-1:0] pc_back;

  always_comb begin
    unique case (cls)
      CL_XFER: go = |pair_cnt;
      CL_SRCH: go = (|pair_cnt) && !zf;
      CL_PORT: go = |byte_cnt;
      default: go = 1'b0;
    endcase
  end

  assign pc_back   = pc_in - BACK;
  assign rsp_valid = (st_q == ST_REPORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rpt     <= 1'b0;
      pc_next <= '0;
      extra_t <= '0;
      mp_we   <= 1'b0;
      mp_val  <= '0;
    end else begin
      st_q <= iter_done ? ST_REPORT : ST_IDLE;
      if (iter_done) begin
        rpt     <= go;
        pc_next <= go ? pc_back : pc_in;
        extra_t <= go ? XT : '0;
        mp_we   <= go && (cls != CL_PORT);
        mp_val  <= pc_back + AW'(1);
      end else begin
        rpt   <= 1'b0;
        mp_we <= 1'b0;
      end
    end
  end
endmodule

module brep_ctrl_chk #(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iter_done,
  input logic [1:0]    cls,
  input logic [AW-1:0] pair_cnt,
  input logic [CW-1:0] byte_cnt,
  input logic          zf,
  input logic [AW-1:0] pc_in,
  input logic          rsp_valid,
  input logic          rpt,
  input logic [AW-1:0] pc_next,
  input logic [TW-1:0] extra_t,
  input logic          mp_we,
  input logic [AW-1:0] mp_val
);
  AST_STROBE_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    iter_done |=> rsp_valid); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !iter_done |=> !rsp_valid); // R7
  AST_XFER_ZERO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_done && cls == 2'd0 && pair_cnt == '0) |=> !rpt); // R8
  AST_MATCH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_done && cls == 2'd1 && zf) |=> !rpt); // R2
  AST_RESERVED_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_done && cls == 2'd3) |=> !rpt); // R9
  AST_PORT_NO_MP: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_done && cls == 2'd2) |=> !mp_we); // R5
  AST_REPEAT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_done && cls == 2'd0 && pair_cnt != '0) |=> (pc_next == $past(pc_in) - AW'(2))); // R4
  AST_STOP_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rpt) |-> (extra_t == '0 && !mp_we)); // R6
  AST_WE_NEEDS_RPT: assert property (@(posedge clk) disable iff (!rst_n)
    mp_we |-> (rpt && rsp_valid)); // R5
endmodule

bind brep_ctrl brep_ctrl_chk #(.AW(AW), .CW(CW), .TW(TW)) u_chk (.*);

// File: tb/brep_ctrl_tb.sv
`timescale 1ns/1ps
module brep_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iter_done = 1'b0;
  logic [1:0] cls = '0;
  logic [15:0] pair_cnt = '0;
  logic [7:0] byte_cnt = '0;
  logic zf = 1'b0;
  logic [15:0] pc_in = '0;
  logic rsp_valid, rpt, mp_we;
  logic [15:0] pc_next, mp_val;
  logic [3:0] extra_t;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic rpt;
    logic [15:0] pc;
    logic [3:0] xt;
    logic we;
    logic [15:0] mp;
    string req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  brep_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .iter_done(iter_done), .cls(cls),
    .pair_cnt(pair_cnt), .byte_cnt(byte_cnt), .zf(zf), .pc_in(pc_in),
    .rsp_valid(rsp_valid), .rpt(rpt), .pc_next(pc_next), .extra_t(extra_t),
    .mp_we(mp_we), .mp_val(mp_val)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic [15:0] bc, input logic [7:0] b,
                       input logic z, input logic [15:0] pc, input string req);
    exp_t e;
    logic go;
    case (c)
      2'd0: go = (bc != 0);
      2'd1: go = (bc != 0) && !z;
      2'd2: go = (b != 0);
      default: go = 1'b0;
    endcase
    e.rpt = go;
    e.pc  = go ? pc - 16'd2 : pc;
    e.xt  = go ? 4'd5 : 4'd0;
    e.we  = go && (c != 2'd2);
    e.mp  = pc - 16'd1;
    e.req = req;
    cls = c; pair_cnt = bc; byte_cnt = b; zf = z; pc_in = pc;
    iter_done = 1'b1;
    sb.push_back(e);
    @(negedge clk);
    iter_done = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R7", "report without strobe", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rpt == e.rpt, e.req, "rpt", rpt, e.rpt);
        check(pc_next == e.pc, e.req, "pc_next", pc_next, e.pc);
        check(extra_t == e.xt, e.req, "extra_t", extra_t, e.xt);
        check(mp_we == e.we, e.req, "mp_we", mp_we, e.we);
        if (e.we) check(mp_val == e.mp, e.req, "mp_val", mp_val, e.mp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", "timeout", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!rsp_valid && !rpt && !mp_we, "R10", "in reset", {rsp_valid, rpt, mp_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rsp_valid && !rpt && !mp_we, "R10", "after reset", {rsp_valid, rpt, mp_we}, 0);
    // transfer
    drive(2'd0, 16'd5,    8'd0, 1'b0, 16'h1234, "R1");
    drive(2'd0, 16'd0,    8'd9, 1'b0, 16'h1234, "R8");
    drive(2'd0, 16'hFFFF, 8'd0, 1'b1, 16'h0001, "R8");
    drive(2'd0, 16'd1,    8'd0, 1'b0, 16'h0000, "R4");
    // search
    drive(2'd1, 16'd3, 8'd0, 1'b0, 16'h4000, "R2");
    drive(2'd1, 16'd3, 8'd0, 1'b1, 16'h4000, "R2");
    drive(2'd1, 16'd0, 8'd0, 1'b0, 16'h4000, "R2");
    // port I/O
    drive(2'd2, 16'd0,    8'd1, 1'b1, 16'h8002, "R3");
    drive(2'd2, 16'hFFFF, 8'd0, 1'b0, 16'h8002, "R3");
    drive(2'd2, 16'd7,    8'hFF, 1'b0, 16'h0010, "R5");
    // reserved
    drive(2'd3, 16'd9, 8'd9, 1'b0, 16'h2222, "R9");
    // stop cases
    drive(2'd0, 16'd0, 8'd0, 1'b0, 16'hABCD, "R6");
    @(negedge clk);
    check(!rsp_valid, "R7", "idle after last report", rsp_valid, 0);
    @(negedge clk);
    check(!rsp_valid, "R7", "no report without strobe", rsp_valid, 0);
    for (int i = 0; i < 6; i++)
      drive(2'(i % 3), 16'(i), 8'(i), 1'(i & 1), 16'(16'h0100 + i), "R7");
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R7", "pending reports", sb.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule